// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps the contents of an asynchronous DRAM alive and brings the device up after power-on. When reset ends, it holds every strobe inactive for a long settling pause. It then runs a burst of initialisation refresh cycles of the type where the column strobe falls before the row strobe. After that burst it raises a ready flag. The DRAM's own internal row counter picks the row in each of these cycles, so the block never drives an address.

In normal operation an interval timer marks each point where one more refresh is owed. At the default settings this is every 15.6 µs, so that 1024 rows are covered in 16 ms. Owed refreshes build up in a saturating pending counter. The block raises `ref_req` toward the access controller. It runs a refresh cycle either when the controller answers with `ref_gnt`, or on its own when the pending count has reached its ceiling. In the second case it also raises `ref_force`. While a refresh runs, and before the ready flag rises, the block owns the strobes (`dram_own`) and refuses host requests.

The refresh waveform works in whole clock cycles:
- The column strobe falls a set number of cycles before the row strobe.
- Both strobes stay low for a hold period.
- The row strobe stays low for its full pulse width.
- Both strobes then stay high for a precharge period before anything else can start.

The write strobe stays high throughout.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is active: `ras_n`, `cas_n` and `we_n` are 1, `dram_own` is 1, and `dram_ready`, `ref_req`, `ref_force` and `host_ack` are 0.
- R2: After reset is released, `cas_n` and `ras_n` stay high for at least PAUSE_CYC clock cycles. The first strobe activity comes no later than two cycles after that.
- R3: After the pause, exactly INIT_CYC refresh cycles run. `dram_ready` rises only after the last of them ends, and `ref_gnt` has no effect during this phase.
- R4: In every refresh cycle, `cas_n` is low for exactly T_CSR cycles before `ras_n` falls. Both strobes are low together for exactly T_CHR cycles. `ras_n` is low for exactly T_RAS cycles. `ras_n` stays high for at least T_RP cycles before it falls again.
- R5: `we_n` is 1 at every cycle, including every falling edge of `ras_n`.
- R6: Once ready, one refresh becomes owed every REF_INTERVAL cycles. `ref_req` is 1 while at least one refresh is owed and the block is idle. With `ref_gnt` held high, refresh cycles occur at that average rate.
- R7: When fewer than MAX_PEND refreshes are owed, no refresh starts while `ref_gnt` is 0. A refresh starts on the clock edge at which `ref_gnt` is sampled high with a refresh owed, so `cas_n` is low one cycle later.
- R8: The pending count saturates at MAX_PEND. At that count `ref_force` is 1 and a refresh starts without `ref_gnt`.
- R9: `host_ack` is 1 only when `host_req` is 1, the block is ready and idle, and no refresh starts in that cycle. It is therefore 0 before ready and in the cycle a forced refresh starts.
- R10: Once `dram_ready` is 1 it stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_gnt | input | 1 | Access controller releases the bus for a refresh |
| host_req | input | 1 | Host asks for the bus |
| ras_n | output | 1 | Row strobe to the DRAM, active low |
| cas_n | output | 1 | Column strobe to the DRAM, active low |
| we_n | output | 1 | Write strobe to the DRAM, held high |
| dram_own | output | 1 | The sequencer drives the strobes |
| dram_ready | output | 1 | Power-up sequence complete |
| ref_req | output | 1 | At least one refresh is owed |
| ref_force | output | 1 | Pending count at ceiling; refresh taken without grant |
| host_ack | output | 1 | Host request accepted this cycle |

## Verification
The bench builds the block with PAUSE_CYC=20 and REF_INTERVAL=30, which shrinks a 200 µs pause and a 15.6 µs interval to a few dozen cycles. The strobe timings, INIT_CYC=8 and MAX_PEND=8 keep their default values. This makes the whole eight-cycle initialisation burst reachable, as is saturation of the pending counter to its full ceiling and the forced refresh that follows, all within a few hundred cycles. The pause and interval lengths can then be measured to the cycle against their parameters.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;
  typedef enum logic [1:0] {
    SEQ_PAUSE = 2'd0,
    SEQ_INIT  = 2'd1,
    SEQ_RUN   = 2'd2,
    SEQ_REF   = 2'd3
  } seq_state_t;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_CSR   = 3'd1,
    PH_HOLD  = 3'd2,
    PH_RAS   = 3'd3,
    PH_PRE   = 3'd4
  } wave_phase_t;
endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int INTERVAL = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= RELOAD;
    else if (!en)             cnt_q <= RELOAD;
    else if (cnt_q == '0)     cnt_q <= RELOAD;
    else                      cnt_q <= cnt_q - 1'b1;
  end

  assign tick = en && (cnt_q == '0);

  // R6
  tick_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick || (INTERVAL == 1));
endmodule

// File: rtl/ref_pending_ctr.sv
module ref_pending_ctr #(
  parameter int MAX_PEND = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic take,
  output logic [$clog2(MAX_PEND+1)-1:0] pend,
  output logic full
);
  localparam int PW = $clog2(MAX_PEND + 1);
  localparam logic [PW-1:0] CEIL = PW'(MAX_PEND);

  logic up;
  assign up = tick && ((pend != CEIL) || take);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else if (up && !take) pend <= pend + 1'b1;
    else if (take && !up) pend <= pend - 1'b1;
  end

  assign full = (pend == CEIL);

  // R8
  pend_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= CEIL);
  // R7
  take_needs_owed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> pend != '0);
endmodule

// File: rtl/cbr_wave_gen.sv
module cbr_wave_gen
  import dram_refresh_pkg::*;
#(
  parameter int T_CSR = 2,
  parameter int T_CHR = 2,
  parameter int T_RAS = 5,
  parameter int T_RP  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done,
  output logic ras_n,
  output logic cas_n
);
  localparam int T_RONLY = T_RAS - T_CHR;
  localparam int M1 = (T_CSR > T_RAS) ? T_CSR : T_RAS;
  localparam int MX = (M1 > T_RP) ? M1 : T_RP;
  localparam int CW = $clog2(MX + 1);

  wave_phase_t   ph_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: if (start) begin
          ph_q  <= PH_CSR;
          cnt_q <= CW'(T_CSR - 1);
        end
        PH_CSR: if (cnt_q == '0) begin
          ph_q  <= PH_HOLD;
          cnt_q <= CW'(T_CHR - 1);
        end else cnt_q <= cnt_q - 1'b1;
        PH_HOLD: if (cnt_q == '0) begin
          ph_q  <= PH_RAS;
          cnt_q <= CW'(T_RONLY - 1);
        end else cnt_q <= cnt_q - 1'b1;
        PH_RAS: if (cnt_q == '0) begin
          ph_q  <= PH_PRE;
          cnt_q <= CW'(T_RP - 1);
        end else cnt_q <= cnt_q - 1'b1;
        PH_PRE: if (cnt_q == '0) ph_q <= PH_IDLE;
                else cnt_q <= cnt_q - 1'b1;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign busy  = (ph_q != PH_IDLE);
  assign done  = (ph_q == PH_PRE) && (cnt_q == '0);
  assign cas_n = !((ph_q == PH_CSR) || (ph_q == PH_HOLD));
  assign ras_n = !((ph_q == PH_HOLD) || (ph_q == PH_RAS));

  // R4
  cas_leads_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> !cas_n && $past(!cas_n));
  // R4
  cas_rise_in_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |-> !ras_n);
  // R4
  ras_rise_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> cas_n);
  // R4
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_refresh_pkg::*;
#(
  parameter int PAUSE_CYC    = 20000,
  parameter int INIT_CYC     = 8,
  parameter int REF_INTERVAL = 1560,
  parameter int MAX_PEND     = 8,
  parameter int T_CSR        = 2,
  parameter int T_CHR        = 2,
  parameter int T_RAS        = 5,
  parameter int T_RP         = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_gnt,
  input  logic host_req,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic dram_own,
  output logic dram_ready,
  output logic ref_req,
  output logic ref_force,
  output logic host_ack
);
  localparam int PCW = (PAUSE_CYC > 1) ? $clog2(PAUSE_CYC) : 1;
  localparam int ICW = $clog2(INIT_CYC + 1);
  localparam int PW  = $clog2(MAX_PEND + 1);

  seq_state_t     st_q;
  logic [PCW-1:0] pause_q;
  logic [ICW-1:0] init_q;
  logic [PW-1:0]  pend;
  logic           pend_full, tick, ref_go, wave_start, wave_busy, wave_done;
  logic           ras_w, cas_w;

  assign dram_ready = (st_q == SEQ_RUN) || (st_q == SEQ_REF);
  assign ref_go     = (st_q == SEQ_RUN) && (pend != '0) && (ref_gnt || pend_full);
  assign wave_start = ((st_q == SEQ_INIT) && !wave_busy && (init_q < ICW'(INIT_CYC))) || ref_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SEQ_PAUSE;
      pause_q <= PCW'(PAUSE_CYC - 1);
      init_q  <= '0;
    end else begin
      case (st_q)
        SEQ_PAUSE: if (pause_q == '0) st_q <= SEQ_INIT;
                   else pause_q <= pause_q - 1'b1;
        SEQ_INIT: begin
          if (wave_start) init_q <= init_q + 1'b1;
          if (wave_done && (init_q == ICW'(INIT_CYC))) st_q <= SEQ_RUN;
        end
        SEQ_RUN: if (ref_go) st_q <= SEQ_REF;
        SEQ_REF: if (wave_done) st_q <= SEQ_RUN;
        default: st_q <= SEQ_PAUSE;
      endcase
    end
  end

  ref_interval_timer #(.INTERVAL(REF_INTERVAL)) i_timer (
    .clk(clk), .rst_n(rst_n), .en(dram_ready), .tick(tick));

  ref_pending_ctr #(.MAX_PEND(MAX_PEND)) i_pend (
    .clk(clk), .rst_n(rst_n), .tick(tick), .take(ref_go),
    .pend(pend), .full(pend_full));

  cbr_wave_gen #(.T_CSR(T_CSR), .T_CHR(T_CHR), .T_RAS(T_RAS), .T_RP(T_RP)) i_wave (
    .clk(clk), .rst_n(rst_n), .start(wave_start), .busy(wave_busy),
    .done(wave_done), .ras_n(ras_w), .cas_n(cas_w));

  assign ras_n     = ras_w;
  assign cas_n     = cas_w;
  assign we_n      = 1'b1;
  assign dram_own  = (st_q != SEQ_RUN);
  assign ref_req   = (st_q == SEQ_RUN) && (pend != '0);
  assign ref_force = (st_q == SEQ_RUN) && pend_full;
  assign host_ack  = host_req && (st_q == SEQ_RUN) && !ref_go;

  // R10
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dram_ready |=> dram_ready);
  // R9
  host_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |-> dram_ready && ras_n && cas_n);
  // R4
  strobes_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !cas_n) |-> dram_own);
  // R2
  pause_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_PAUSE) |-> ras_n && cas_n);
endmodule

// File: tb/test_dram_refresh_seq.sv
module test_dram_refresh_seq;
  localparam int PAUSE = 20;
  localparam int INIT  = 8;
  localparam int INTV  = 30;
  localparam int MAXP  = 8;
  localparam int TCSR  = 2;
  localparam int TCHR  = 2;
  localparam int TRAS  = 5;
  localparam int TRP   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_gnt = 1'b0;
  logic host_req = 1'b0;
  logic ras_n, cas_n, we_n, dram_own, dram_ready, ref_req, ref_force, host_ack;

  int checks = 0;
  int fails = 0;
  int falls = 0;
  bit done_flag = 0;
  bit ready_seen = 0;
  bit ready_drop = 0;

  always #5 clk = ~clk;

  dram_refresh_seq #(
    .PAUSE_CYC(PAUSE), .INIT_CYC(INIT), .REF_INTERVAL(INTV), .MAX_PEND(MAXP),
    .T_CSR(TCSR), .T_CHR(TCHR), .T_RAS(TRAS), .T_RP(TRP)
  ) i_dram_refresh_seq (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .host_req(host_req),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .dram_own(dram_own),
    .dram_ready(dram_ready), .ref_req(ref_req), .ref_force(ref_force),
    .host_ack(host_ack));

  function automatic void chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endfunction

  // waveform monitor for R4/R5/R10
  bit prev_ras = 1'b1;
  int cas_pre = 0, both = 0, low_run = 0, high_run = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!we_n) chk(0, "R5 we_n", 0, 1);
      if (ready_seen && !dram_ready) ready_drop = 1;
      if (dram_ready) ready_seen = 1;
      if (!ras_n && prev_ras) begin
        falls++;
        chk(cas_pre == TCSR, "R4 cas lead", cas_pre, TCSR);
        chk(we_n == 1'b1, "R5 we_n at ras fall", we_n, 1);
        if (falls > 1) chk(high_run >= TRP, "R4 precharge", high_run, TRP);
        low_run = 1;
        both = cas_n ? 0 : 1;
      end else if (!ras_n) begin
        low_run++;
        if (!cas_n) both++;
      end else if (ras_n && !prev_ras) begin
        chk(low_run == TRAS, "R4 ras width", low_run, TRAS);
        chk(both == TCHR, "R4 cas hold", both, TCHR);
        high_run = 1;
        cas_pre = 0;
      end else begin
        high_run++;
        cas_pre = cas_n ? 0 : cas_pre + 1;
      end
      prev_ras = ras_n;
    end
  end

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && we_n, "R1 strobes", {ras_n, cas_n, we_n}, 7);
    chk(dram_own == 1'b1, "R1 dram_own", dram_own, 1);
    chk(!dram_ready && !ref_req && !ref_force, "R1 flags",
        {dram_ready, ref_req, ref_force}, 0);
    host_req = 1'b1;
    @(negedge clk);
    chk(host_ack == 1'b0, "R1 host_ack", host_ack, 0);
  endtask

  task automatic t_pause_init();
    int quiet = 0;
    @(negedge clk) rst_n = 1'b1;
    ref_gnt = 1'b1;  // must have no effect during init (R3)
    while (cas_n && ras_n && quiet < PAUSE + 10) begin
      quiet++;
      @(negedge clk);
    end
    chk(quiet >= PAUSE && quiet <= PAUSE + 2, "R2 pause length", quiet, PAUSE);
    while (!dram_ready) begin
      chk(host_ack == 1'b0, "R9 refused before ready", host_ack, 0);
      @(negedge clk);
    end
    chk(falls == INIT, "R3 init refresh count", falls, INIT);
    host_req = 1'b0;
    ref_gnt = 1'b0;
  endtask

  task automatic t_grant();
    int n = 0;
    int f0 = falls;
    while (!ref_req && n < INTV + 10) begin
      n++;
      @(negedge clk);
    end
    chk(n >= INTV - 1 && n <= INTV + 3, "R6 first owed interval", n, INTV + 1);
    repeat (10) @(negedge clk);
    chk(falls == f0 && ref_req, "R7 no refresh without grant", falls - f0, 0);
    ref_gnt = 1'b1;
    @(negedge clk);
    chk(cas_n == 1'b0, "R7 start after grant", cas_n, 0);
    ref_gnt = 1'b0;
    repeat (12) @(negedge clk);
    chk(falls == f0 + 1, "R7 one refresh ran", falls - f0, 1);
    chk(ref_req == 1'b0, "R6 ref_req clears", ref_req, 0);
    host_req = 1'b1;
    @(negedge clk);
    chk(host_ack == 1'b1, "R9 host accepted when idle", host_ack, 1);
    host_req = 1'b0;
  endtask

  task automatic t_saturate();
    int n = 0;
    int f0 = falls;
    int guard = 0;
    while (!ref_force && n < MAXP * INTV + 20) begin
      n++;
      @(negedge clk);
    end
    chk(n >= (MAXP - 1) * INTV && n <= MAXP * INTV + 3, "R8 time to ceiling", n, MAXP * INTV);
    chk(falls == f0, "R7 no refresh while pending below ceiling", falls - f0, 0);
    host_req = 1'b1;
    #1;
    chk(host_ack == 1'b0, "R9 refused at forced start", host_ack, 0);
    @(negedge clk);
    host_req = 1'b0;
    chk(cas_n == 1'b0, "R8 forced refresh starts", cas_n, 0);
    ref_gnt = 1'b1;
    while ((ref_req || dram_own) && guard < 200) begin
      guard++;
      @(negedge clk);
    end
    chk(!ref_req && !dram_own, "R6 backlog drains", ref_req, 0);
    chk(falls - f0 >= MAXP, "R8 backlog refreshes", falls - f0, MAXP);
  endtask

  task automatic t_rate();
    int f0 = falls;
    repeat (10 * INTV) @(negedge clk);
    chk(falls - f0 >= 9 && falls - f0 <= 11, "R6 refresh rate", falls - f0, 10);
    ref_gnt = 1'b0;
    chk(dram_ready && !ready_drop, "R10 ready sticky", dram_ready, 1);
  endtask

  initial begin : main
    t_reset();
    t_pause_init();
    t_grant();
    t_saturate();
    t_rate();
    finish_run();
  end
endmodule